// File: doc/BRIEF.md
# Doorbell Mailbox Command Dispatcher

This block lets a host hand a single command to a device through a small set of registers. The host sets up a payload buffer and writes a command word, which holds a command-set byte, a command byte and an input length. It then rings a doorbell bit. The dispatcher joins the two bytes into a 16-bit opcode and looks it up in a built-in command table. It checks the input length against the table and runs the matching built-in responder. When it is done it returns a result code and an output length, and it clears the doorbell.

The responders are small by design. Some overwrite the front of the payload buffer with a fixed number of zero bytes and report that count as the output length. The others are no-ops that report success and leave the length unchanged. A responder whose output would not fit in the payload buffer reports an internal error and writes nothing. While the doorbell is set, the command word, the payload and the doorbell cannot be changed from the host side.

Register map (word addresses on `wr_addr` and `rd_addr`):
- 0 is control. Bit 0 is the doorbell.
- 1 is the command word: [7:0] command, [15:8] command set, [31:16] length.
- 2 is status. Bits [7:0] hold the result code.
- `PAY_BASE` to `PAY_BASE+PAY_WORDS-1` are the payload words. Payload byte 4k+j sits in word k, bits [8j+7:8j].
- Reads from any other address return 0.

Top module: `mbx_dispatch`

## Requirements
- R1: After a synchronous active-low reset, control, command word, status and every payload word all read 0.
- R2: An opcode that is not in the table completes with result code 0x03 and leaves the payload untouched. The table holds 0x0100, 0x0101, 0x0102, 0x0103 and 0x0200, where opcode = set<<8 | command.
- R3: When the input length differs from the opcode's expected length, the command completes with code 0x16 and no responder runs. The expected lengths are 0x0100:1, 0x0102:0, 0x0103:4 and 0x0200:0.
- R4: Opcode 0x0101 has an expected length of 0xFFFF, which means any length is accepted. It completes with code 0x00, the length is unchanged and the payload is untouched. 0x0103 with length 4 behaves the same way.
- R5: 0x0100 zeroes payload bytes 0..31 and 0x0102 zeroes bytes 0..3. Both report code 0x00 and set the output length to the number of bytes zeroed. Bytes beyond the zeroed range keep their values.
- R6: On completion the command word has bits [15:0] equal to 0. Its length field holds the output length on success and the host's length on any error.
- R7: Completion writes the result code into status and clears the doorbell within PAY_WORDS+4 cycles of the doorbell being set.
- R8: While the doorbell reads 1, host writes to control, the command word and the payload have no effect. This holds in the very cycle of completion as well.
- R9: A responder whose output would exceed the payload buffer (0x0200 wants 80 bytes, the buffer holds 64) completes with code 0x04 and leaves the payload untouched.
- R10: Each doorbell assertion runs exactly one command. Status and payload stay unchanged while the doorbell is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
The case that needs care is a host write arriving in the same cycle in which the engine finishes. In that cycle the completion writes back the command word and status and clears the doorbell. The bench provokes this by sending one junk write every cycle while the doorbell is set. Each write goes to the command word, a payload word or control, and the bench stops only when it sees the doorbell clear, so one junk write always lands on the completion edge. The bench judges the outcome by reading back the command word, the status and all sixteen payload words. It compares them with values it computes for every opcode in a sweep over sets 0..3, commands 0..7 and five input lengths. Any junk that got in shows up as a mismatch.

// File: rtl/mbx_pkg.sv
// Package: shared types, result codes and the command table of the mailbox.
// Assumes 16-bit opcodes (set<<8 | command) and byte lengths of 16 bits.
package mbx_pkg;

    localparam logic [7:0]  RC_OK       = 8'h00;
    localparam logic [7:0]  RC_BAD_IN   = 8'h02;
    localparam logic [7:0]  RC_UNSUP    = 8'h03;
    localparam logic [7:0]  RC_INTERNAL = 8'h04;
    localparam logic [7:0]  RC_BAD_LEN  = 8'h16;
    localparam logic [15:0] LEN_ANY     = 16'hFFFF;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DONE} eng_state_t;

    typedef struct packed {
        logic        known;
        logic [15:0] need_len;
        logic [15:0] zero_bytes;
    } cmd_entry_t;

    // Table of supported opcodes: expected input length and zero-fill size.
    function automatic cmd_entry_t cmd_lookup(input logic [15:0] op);
        cmd_entry_t e;
        e = '{known: 1'b0, need_len: 16'h0, zero_bytes: 16'h0};
        case (op)
            16'h0100: e = '{known: 1'b1, need_len: 16'd1,   zero_bytes: 16'h20};
            16'h0101: e = '{known: 1'b1, need_len: LEN_ANY, zero_bytes: 16'h0};
            16'h0102: e = '{known: 1'b1, need_len: 16'd0,   zero_bytes: 16'h4};
            16'h0103: e = '{known: 1'b1, need_len: 16'd4,   zero_bytes: 16'h0};
            16'h0200: e = '{known: 1'b1, need_len: 16'd0,   zero_bytes: 16'h50};
            default:  e = '{known: 1'b0, need_len: 16'h0,   zero_bytes: 16'h0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/mbx_cmd_table.sv
// Command table: maps an opcode to its table entry. Purely combinational.
// Assumes the opcode is held stable by the register block while in use.
module mbx_cmd_table
    import mbx_pkg::*;
(
    input  logic [15:0] op,
    output cmd_entry_t  entry
);
    // Look up the entry for the current opcode.
    always_comb entry = cmd_lookup(op);
endmodule

// File: rtl/mbx_payload_ram.sv
// Payload buffer of PAY_WORDS 32-bit words with a host write port, an
// engine clear port and a combinational read port.
// Assumes the host and clear ports are never active in the same cycle.
module mbx_payload_ram #(
    parameter int PAY_WORDS = 16,
    localparam int IDX_W = $clog2(PAY_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_data,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);
    logic [31:0] mem [PAY_WORDS];

    for (genvar w = 0; w < PAY_WORDS; w++) begin : g_word
        // Store one word: reset, engine clear or host write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[w] <= '0;
            else if (clr_en && clr_idx == IDX_W'(w))
                mem[w] <= '0;
            else if (host_we && host_idx == IDX_W'(w))
                mem[w] <= host_data;
        end
    end

    // Read the addressed word.
    always_comb rd_word = mem[rd_idx];

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && clr_en)); // R8
endmodule

// File: rtl/mbx_engine.sv
// Command engine: on a set doorbell it checks the opcode and length,
// zero-fills the payload when the responder asks for it, then emits one
// write-back pulse carrying the result code and output length.
// Assumes the doorbell stays set until the write-back pulse is consumed.
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int PAY_WORDS = 16,
    localparam int IDX_W = $clog2(PAY_WORDS),
    localparam int PAY_BYTES = PAY_WORDS * 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             doorbell,
    input  logic [15:0]      in_len,
    input  cmd_entry_t       entry,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             wb_valid,
    output logic [7:0]       wb_code,
    output logic [15:0]      wb_len
);
    eng_state_t       state;
    logic [IDX_W-1:0] cnt, last_idx;
    logic [7:0]       dec_code;
    logic [15:0]      dec_len, dec_words;

    // Decide the result of the pending command from the table entry.
    always_comb begin
        dec_words = (entry.zero_bytes + 16'd3) >> 2;
        dec_len   = in_len;
        if (!entry.known)
            dec_code = RC_UNSUP;
        else if (entry.need_len != LEN_ANY && entry.need_len != in_len)
            dec_code = RC_BAD_LEN;
        else if (entry.zero_bytes > 16'(PAY_BYTES))
            dec_code = RC_INTERNAL;
        else begin
            dec_code = RC_OK;
            if (entry.zero_bytes != 16'h0)
                dec_len = entry.zero_bytes;
        end
    end

    // Sequence decode, zero fill and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            last_idx <= '0;
            wb_code  <= RC_OK;
            wb_len   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (doorbell) begin
                    wb_code  <= dec_code;
                    wb_len   <= dec_len;
                    cnt      <= '0;
                    last_idx <= IDX_W'(dec_words - 16'd1);
                    state    <= (dec_code == RC_OK && dec_words != 16'h0)
                                ? ST_FILL : ST_DONE;
                end
                ST_FILL: begin
                    if (cnt == last_idx) state <= ST_DONE;
                    else                 cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the clear port and the write-back pulse from the state.
    always_comb begin
        clr_en   = (state == ST_FILL);
        clr_idx  = cnt;
        wb_valid = (state == ST_DONE);
    end

    AST_SINGLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R10
    AST_OK_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_code == RC_OK && entry.zero_bytes != 16'h0)
        |-> wb_len <= 16'(PAY_BYTES)); // R9
endmodule

// File: rtl/mbx_dispatch.sv
// Mailbox dispatcher top: control, command and status registers, the host
// register port, the payload buffer, the command table and the engine.
// Assumes PAY_BASE leaves room below it for the three control registers.
module mbx_dispatch
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PAY_WORDS = 16,
    parameter int PAY_BASE  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int IDX_W = $clog2(PAY_WORDS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(2);
    localparam int BUSY_LIMIT = PAY_WORDS + 4;

    logic             db_q;
    logic [31:0]      cmd_q;
    logic [7:0]       sts_q;
    cmd_entry_t       entry;
    logic             clr_en, wb_valid;
    logic [IDX_W-1:0] clr_idx;
    logic [7:0]       wb_code;
    logic [15:0]      wb_len;
    logic             wr_pay, rd_pay, host_we;
    logic [ADDR_W-1:0] wr_off, rd_off;
    logic [31:0]      pay_word;

    // Decode whether the write and read addresses hit the payload window.
    always_comb begin
        wr_off  = wr_addr - ADDR_W'(PAY_BASE);
        rd_off  = rd_addr - ADDR_W'(PAY_BASE);
        wr_pay  = (wr_addr >= ADDR_W'(PAY_BASE)) && (wr_off < ADDR_W'(PAY_WORDS));
        rd_pay  = (rd_addr >= ADDR_W'(PAY_BASE)) && (rd_off < ADDR_W'(PAY_WORDS));
        host_we = wr_en && !db_q && wr_pay;
    end

    mbx_cmd_table u_table (
        .op    (cmd_q[15:0]),
        .entry (entry)
    );

    mbx_engine #(.PAY_WORDS(PAY_WORDS)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .doorbell (db_q),
        .in_len   (cmd_q[31:16]),
        .entry    (entry),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .wb_valid (wb_valid),
        .wb_code  (wb_code),
        .wb_len   (wb_len)
    );

    mbx_payload_ram #(.PAY_WORDS(PAY_WORDS)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_idx  (wr_off[IDX_W-1:0]),
        .host_data (wr_data),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .rd_idx    (rd_off[IDX_W-1:0]),
        .rd_word   (pay_word)
    );

    // Update registers: completion write-back first, host writes only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q  <= 1'b0;
            cmd_q <= '0;
            sts_q <= '0;
        end else if (wb_valid) begin
            cmd_q <= {wb_len, 16'h0000};
            sts_q <= wb_code;
            db_q  <= 1'b0;
        end else if (wr_en && !db_q) begin
            if (wr_addr == A_CTRL) db_q  <= wr_data[0];
            if (wr_addr == A_CMD)  cmd_q <= wr_data;
        end
    end

    // Return the register or payload word addressed by rd_addr.
    always_comb begin
        if (rd_pay)                 rd_data = pay_word;
        else if (rd_addr == A_CTRL) rd_data = {31'h0, db_q};
        else if (rd_addr == A_CMD)  rd_data = cmd_q;
        else if (rd_addr == A_STS)  rd_data = {24'h0, sts_q};
        else                        rd_data = '0;
    end

    // Count how long the doorbell has been set, for the completion bound.
    logic [7:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !db_q) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 8'd1;
    end

    AST_DB_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 8'(BUSY_LIMIT)); // R7
    AST_STS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(db_q) |-> $stable(sts_q)); // R10
    AST_WB_CLEARS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (cmd_q[15:0] == 16'h0 && !db_q)); // R6
    AST_CLEAR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> db_q); // R10
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(db_q) && db_q) |-> $stable(cmd_q)); // R8
endmodule

// File: tb/tb_mbx_dispatch.sv
// Bench: sweeps opcodes and lengths, jams host writes while busy, and checks
// command word, status and every payload word against computed values.
module tb_mbx_dispatch;
    localparam int AW = 6;
    localparam int PW = 16;
    localparam int PB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    mbx_dispatch #(.ADDR_W(AW), .PAY_WORDS(PW), .PAY_BASE(PB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = AW'(a);
        #0.5;
        d = rd_data;
    endtask

    function automatic logic [31:0] pat(input int idx, input int w);
        return {idx[15:0], 8'hA5, w[7:0]};
    endfunction

    // Expected behaviour from the requirements.
    task automatic model(input logic [15:0] op, input logic [15:0] len,
                         output logic [7:0] code, output logic [15:0] olen,
                         output int zwords);
        logic known; logic [15:0] need; int zb;
        known = 1'b1; need = 16'h0; zb = 0;
        case (op)
            16'h0100: begin need = 16'd1;    zb = 32; end
            16'h0101: begin need = 16'hFFFF; end
            16'h0102: begin need = 16'd0;    zb = 4;  end
            16'h0103: begin need = 16'd4;    end
            16'h0200: begin need = 16'd0;    zb = 80; end
            default:  known = 1'b0;
        endcase
        olen = len; zwords = 0;
        if (!known)                                 code = 8'h03;
        else if (need != 16'hFFFF && need != len)  code = 8'h16;
        else if (zb > PW * 4)                       code = 8'h04;
        else begin
            code = 8'h00;
            if (zb > 0) begin olen = 16'(zb); zwords = zb / 4; end
        end
    endtask

    task automatic run(input int idx, input logic [7:0] set,
                       input logic [7:0] cmd, input logic [15:0] len);
        logic [31:0] d; logic [7:0] ecode; logic [15:0] elen; int zw;
        int k; int guard;
        string rq;
        for (int w = 0; w < PW; w++) wr(PB + w, pat(idx, w));
        wr(1, {len, set, cmd});
        wr(0, 32'h1);
        // Jam writes every busy cycle, including the completion cycle (R8).
        rd_addr = AW'(0);
        k = 0; guard = 0;
        forever begin
            @(negedge clk);
            #0.5;
            if (rd_data[0] == 1'b0) begin wr_en = 1'b0; break; end
            if (guard > 100) begin
                wr_en = 1'b0;
                check("R7", "watchdog doorbell", rd_data, 32'h0);
                break;
            end
            wr_en = 1'b1;
            case (k % 3)
                0: begin wr_addr = AW'(1);          wr_data = 32'hDEAD_BEEF; end
                1: begin wr_addr = AW'(PB + k % PW); wr_data = 32'hBAD0_0000 | k; end
                default: begin wr_addr = AW'(0);    wr_data = 32'h0; end
            endcase
            k++; guard++;
        end
        model({set, cmd}, len, ecode, elen, zw);
        rq = (ecode == 8'h03) ? "R2" : (ecode == 8'h16) ? "R3" :
             (ecode == 8'h04) ? "R9" : (zw > 0) ? "R5" : "R4";
        rd(2, d); check(rq, "status code R7", d, {24'h0, ecode});
        rd(1, d); check("R6", "command word", d, {elen, 16'h0});
        for (int w = 0; w < PW; w++) begin
            rd(PB + w, d);
            check(rq, "payload word R8", d, (w < zw) ? 32'h0 : pat(idx, w));
        end
        repeat (4) @(negedge clk);
        rd(2, d); check("R10", "status held", d, {24'h0, ecode});
        rd(0, d); check("R10", "doorbell idle", d, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        int idx;
        logic [15:0] lens [5];
        lens[0] = 16'd0; lens[1] = 16'd1; lens[2] = 16'd4;
        lens[3] = 16'd8; lens[4] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(0, d); check("R1", "control", d, 32'h0);
        rd(1, d); check("R1", "command", d, 32'h0);
        rd(2, d); check("R1", "status", d, 32'h0);
        for (int w = 0; w < PW; w++) begin
            rd(PB + w, d); check("R1", "payload", d, 32'h0);
        end
        idx = 1;
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 8; c++)
                for (int l = 0; l < 5; l++) begin
                    run(idx, 8'(s), 8'(c), lens[l]);
                    idx++;
                end
        run(idx, 8'hFF, 8'hFF, 16'd0);   // R2 far opcode
        idx++;
        run(idx, 8'h01, 8'h01, 16'd777); // R4 any length
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Global watchdog: counts as a failed check and still reports.
    initial begin
        #(5ns * 150000);
        fails++; checks++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule